// File: doc/BRIEF.md
# Branch and Trap Condition Evaluator

This unit settles every control-transfer decision of a 32-bit pipeline in one place. For each operation it receives the first operand (the source register value), the second operand (the target register value), the address of the control instruction itself, an offset field and a 5-bit operation code. One clock later it returns the taken decision, the address execution continues from after the delay slot, the return address and whether a link write is needed, a flag that cancels the delay-slot instruction, and a trap request.

It covers equality branches, branches that test the sign of the first operand against zero, the linking and "likely" variants of those, jumps into the current 256 MB region, jumps to a register, and conditional traps that compare the first operand, signed or unsigned, against the second operand or a sign-extended immediate. Signed and unsigned orderings for the traps come from a single 33-bit subtraction. Fetch redirection and exception vectoring are left to the neighbouring stages.

Top module: `bte_top`

## Requirements
- R1: The outputs are registered: `res_valid` equals the `op_valid` sampled at the previous rising edge; in a cycle with `res_valid` low, `taken`, `annul`, `link_en`, `link_rd` and `trap_req` are 0 and `next_pc` and `link_addr` keep their previous values. Reset (synchronous, `rst_n` low) clears every output to 0.
- R2: Codes 0 (branch if equal) and 1 (branch if not equal), and their likely forms 8 and 9, are taken when `rs_val == rt_val`, respectively `rs_val != rt_val`.
- R3: Codes 2 (less-or-equal zero) and 3 (greater than zero), likely forms 10 and 11: code 2 is taken when bit 31 of `rs_val` is set or `rs_val` is zero; code 3 when bit 31 is clear and `rs_val` is nonzero.
- R4: Codes 4 and 6 (less than zero), 5 and 7 (greater-or-equal zero), likely forms 12, 14, 13, 15, look only at bit 31 of `rs_val`: set for 4/6/12/14, clear for 5/7/13/15.
- R5: A taken branch (codes 0 to 15) gives `next_pc = pc + 4 + (sign_extend(offset[15:0]) << 2)`; a branch not taken gives `next_pc = pc + 8`.
- R6: Codes 6, 7, 14 and 15 assert `link_en` with `link_rd = 0` (write register 31) whether or not they are taken; `link_addr` is `pc + 8` for every valid operation.
- R7: Likely branches (codes 8 to 15) assert `annul` exactly when not taken; no other code ever asserts `annul`.
- R8: Codes 16 (region jump) and 17 (region jump with link to register 31) are always taken with `next_pc = {pc[31:28], offset[25:0], 2'b00}`; code 17 asserts `link_en`.
- R9: Codes 18 (register jump) and 19 (register jump with link) are always taken with `next_pc = rs_val`; code 19 asserts `link_en` and `link_rd = 1` (write the instruction's destination register).
- R10: Register trap codes 20 to 25 raise `trap_req` when, in order, `rs_val` equals, differs from, is signed greater-or-equal, unsigned greater-or-equal, signed less than, unsigned less than `rt_val`.
- R11: Immediate trap codes 26 to 31 use the same six conditions in the same order against `sign_extend(offset[15:0])`, sign extension applying to the unsigned compares too; `rt_val` is not consulted.
- R12: A trap code never asserts `taken`, `annul` or `link_en`, and gives `next_pc = pc + 4`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation code (see R2 to R12) |
| rs_val | input | 32 | First operand |
| rt_val | input | 32 | Second operand |
| pc | input | 32 | Address of the control instruction |
| offset | input | 26 | Branch/trap immediate in bits 15:0, region jump index in 25:0 |
| res_valid | output | 1 | Result registered from a valid operation |
| taken | output | 1 | Control transfer happens |
| next_pc | output | 32 | Address to continue from after the delay slot |
| link_addr | output | 32 | Return address, pc + 8 |
| link_en | output | 1 | Write the return address |
| link_rd | output | 1 | 1: write to destination register; 0: write to register 31 |
| annul | output | 1 | Cancel the delay-slot instruction |
| trap_req | output | 1 | Trap condition met |

## Verification
Every decision is recomputed each operation and captured in a single register stage, so a wrong compare or decode shows on the ports in the cycle right after the offending operation and only for the codes that use it; nothing persists except the held addresses during idle cycles. A wrong sign or borrow term in the shared subtraction surfaces as a mismatch of `trap_req` only at operand pairs that straddle the sign boundary, which is why the sweep crosses every code with operands at 0, ±1, ±2 and both extremes of the signed range, and immediates of both signs. A stale or leaking output register shows as a nonzero flag or a changed address on an idle cycle that follows a taken operation.

// File: rtl/bte_pkg.sv
// Package: shared operation codes and next-address selector for the
// branch and trap evaluator. Assumes a 5-bit operation field.
package bte_pkg;

    typedef enum logic [4:0] {
        OP_BEQ     = 5'd0,  OP_BNE     = 5'd1,  OP_BLEZ    = 5'd2,  OP_BGTZ    = 5'd3,
        OP_BLTZ    = 5'd4,  OP_BGEZ    = 5'd5,  OP_BLTZAL  = 5'd6,  OP_BGEZAL  = 5'd7,
        OP_BEQL    = 5'd8,  OP_BNEL    = 5'd9,  OP_BLEZL   = 5'd10, OP_BGTZL   = 5'd11,
        OP_BLTZL   = 5'd12, OP_BGEZL   = 5'd13, OP_BLTZALL = 5'd14, OP_BGEZALL = 5'd15,
        OP_JREGION = 5'd16, OP_JREGLNK = 5'd17, OP_JREG    = 5'd18, OP_JREGRLNK = 5'd19,
        OP_TEQ     = 5'd20, OP_TNE     = 5'd21, OP_TGE     = 5'd22, OP_TGEU    = 5'd23,
        OP_TLT     = 5'd24, OP_TLTU    = 5'd25, OP_TEQI    = 5'd26, OP_TNEI    = 5'd27,
        OP_TGEI    = 5'd28, OP_TGEIU   = 5'd29, OP_TLTI    = 5'd30, OP_TLTIU   = 5'd31
    } op_e;

    // First immediate-form trap code; codes at or above it compare against the immediate.
    localparam logic [4:0] TRAP_IMM_BASE = 5'd26;
    localparam logic [4:0] TRAP_REG_BASE = 5'd20;

    typedef enum logic [1:0] {
        NPC_SEQ4   = 2'd0,  // trap: fall through
        NPC_SEQ8   = 2'd1,  // branch not taken: skip delay slot
        NPC_BRANCH = 2'd2,  // relative branch target
        NPC_JUMP   = 2'd3   // region or register jump target (chosen separately)
    } npc_sel_e;

endpackage

// File: rtl/bte_cmp.sv
// Module: bte_cmp
// Shared comparator. One (W+1)-bit subtraction yields the unsigned
// less-than as its borrow; the signed less-than is derived from the
// borrow and the two sign bits. Assumes two's-complement operands.
module bte_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         eq,
    output logic         lt_s,
    output logic         lt_u
);
    logic [W:0] diff;

    // Form the difference and derive all three relations from it.
    always_comb begin
        diff = {1'b0, a} - {1'b0, b};
        eq   = (a == b);
        lt_u = diff[W];
        lt_s = (a[W-1] ^ b[W-1]) ? a[W-1] : diff[W];
    end
endmodule

// File: rtl/bte_addr.sv
// Module: bte_addr
// Candidate address generator: sequential addresses, the relative branch
// target (offset counted from the delay slot), the region jump target and
// the register jump target. Assumes instructions are 4 bytes.
module bte_addr #(
    parameter int W     = 32,
    parameter int IMM_W = 16,
    parameter int IDX_W = 26
) (
    input  logic [W-1:0]     pc,
    input  logic [W-1:0]     rs,
    input  logic [IDX_W-1:0] offs,
    output logic [W-1:0]     seq4,
    output logic [W-1:0]     seq8,
    output logic [W-1:0]     br_tgt,
    output logic [W-1:0]     rgn_tgt,
    output logic [W-1:0]     reg_tgt
);
    localparam int REGION_W = W - IDX_W - 2;
    localparam int EXT_W    = W - IMM_W - 2;

    logic [W-1:0] br_disp;

    // Compute the sequential and target addresses in parallel.
    always_comb begin
        seq4    = pc + W'(4);
        seq8    = pc + W'(8);
        br_disp = {{EXT_W{offs[IMM_W-1]}}, offs[IMM_W-1:0], 2'b00};
        br_tgt  = seq4 + br_disp;
        rgn_tgt = {pc[W-1 -: REGION_W], offs, 2'b00};
        reg_tgt = rs;
    end
endmodule

// File: rtl/bte_decide.sv
// Module: bte_decide
// Decision decoder. From the operation code, the comparator flags and
// the sign/zero state of the first operand, it decides taken, annul,
// link, trap and which next address applies. Purely combinational.
module bte_decide
    import bte_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [4:0]   op,
    input  logic [W-1:0] rs,
    input  logic         eq,
    input  logic         lt_s,
    input  logic         lt_u,
    output logic         taken,
    output logic         annul,
    output logic         link_en,
    output logic         link_rd,
    output logic         trap,
    output logic         jmp_reg,
    output npc_sel_e     npc_sel
);
    logic       neg;
    logic       zero;
    logic       cond;
    logic [2:0] tidx;

    // Sign and zero state of the first operand for the compare-to-zero branches.
    always_comb begin
        neg  = rs[W-1];
        zero = (rs == '0);
    end

    // Decode the operation into decisions.
    always_comb begin
        taken   = 1'b0;
        annul   = 1'b0;
        link_en = 1'b0;
        link_rd = 1'b0;
        trap    = 1'b0;
        jmp_reg = 1'b0;
        npc_sel = NPC_SEQ4;
        cond    = 1'b0;
        tidx    = 3'd0;
        if (op[4] == 1'b0) begin
            // Branch family: low three bits pick the condition, bit 3 marks likely.
            case (op[2:0])
                3'd0:       cond = eq;
                3'd1:       cond = !eq;
                3'd2:       cond = neg || zero;
                3'd3:       cond = !neg && !zero;
                3'd4, 3'd6: cond = neg;
                default:    cond = !neg;
            endcase
            taken   = cond;
            annul   = op[3] && !cond;
            link_en = (op[2:1] == 2'b11);
            npc_sel = cond ? NPC_BRANCH : NPC_SEQ8;
        end else if (op < TRAP_REG_BASE) begin
            // Jump family: always taken; bit 1 selects register target, bit 0 links.
            taken   = 1'b1;
            jmp_reg = op[1];
            link_en = op[0];
            link_rd = op[1] && op[0];
            npc_sel = NPC_JUMP;
        end else begin
            // Trap family: six conditions repeated for register and immediate forms.
            tidx = (op >= TRAP_IMM_BASE) ? 3'(op - TRAP_IMM_BASE) : 3'(op - TRAP_REG_BASE);
            case (tidx)
                3'd0:    trap = eq;
                3'd1:    trap = !eq;
                3'd2:    trap = !lt_s;
                3'd3:    trap = !lt_u;
                3'd4:    trap = lt_s;
                default: trap = lt_u;
            endcase
            npc_sel = NPC_SEQ4;
        end
    end
endmodule

// File: rtl/bte_top.sv
// Module: bte_top
// Branch and trap condition evaluator. Selects the second compare operand
// (register or sign-extended immediate), runs the shared comparator, the
// address generator and the decoder, and registers every result one cycle
// after op_valid. Idle cycles clear the flags and hold the addresses.
module bte_top
    import bte_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 16,
    parameter int IDX_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [4:0]       op_code,
    input  logic [W-1:0]     rs_val,
    input  logic [W-1:0]     rt_val,
    input  logic [W-1:0]     pc,
    input  logic [IDX_W-1:0] offset,
    output logic             res_valid,
    output logic             taken,
    output logic [W-1:0]     next_pc,
    output logic [W-1:0]     link_addr,
    output logic             link_en,
    output logic             link_rd,
    output logic             annul,
    output logic             trap_req
);
    localparam int SEXT_W = W - IMM_W;

    logic [W-1:0] cmp_b;
    logic         use_imm;
    logic         c_eq, c_lt_s, c_lt_u;
    logic [W-1:0] a_seq4, a_seq8, a_br, a_rgn, a_reg;
    logic         d_taken, d_annul, d_link_en, d_link_rd, d_trap, d_jmp_reg;
    npc_sel_e     d_sel;
    logic [W-1:0] npc_mux;

    // Pick the second compare operand: immediate trap forms use the sign-extended offset.
    always_comb begin
        use_imm = (op_code >= TRAP_IMM_BASE);
        cmp_b   = use_imm ? {{SEXT_W{offset[IMM_W-1]}}, offset[IMM_W-1:0]} : rt_val;
    end

    bte_cmp #(.W(W)) u_cmp (
        .a    (rs_val),
        .b    (cmp_b),
        .eq   (c_eq),
        .lt_s (c_lt_s),
        .lt_u (c_lt_u)
    );

    bte_addr #(.W(W), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_addr (
        .pc      (pc),
        .rs      (rs_val),
        .offs    (offset),
        .seq4    (a_seq4),
        .seq8    (a_seq8),
        .br_tgt  (a_br),
        .rgn_tgt (a_rgn),
        .reg_tgt (a_reg)
    );

    bte_decide #(.W(W)) u_dec (
        .op      (op_code),
        .rs      (rs_val),
        .eq      (c_eq),
        .lt_s    (c_lt_s),
        .lt_u    (c_lt_u),
        .taken   (d_taken),
        .annul   (d_annul),
        .link_en (d_link_en),
        .link_rd (d_link_rd),
        .trap    (d_trap),
        .jmp_reg (d_jmp_reg),
        .npc_sel (d_sel)
    );

    // Choose the next address from the candidates.
    always_comb begin
        case (d_sel)
            NPC_SEQ8:   npc_mux = a_seq8;
            NPC_BRANCH: npc_mux = a_br;
            NPC_JUMP:   npc_mux = d_jmp_reg ? a_reg : a_rgn;
            default:    npc_mux = a_seq4;
        endcase
    end

    // Output register stage: capture on valid, clear flags and hold addresses when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            taken     <= 1'b0;
            annul     <= 1'b0;
            link_en   <= 1'b0;
            link_rd   <= 1'b0;
            trap_req  <= 1'b0;
            next_pc   <= '0;
            link_addr <= '0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                taken     <= d_taken;
                annul     <= d_annul;
                link_en   <= d_link_en;
                link_rd   <= d_link_rd;
                trap_req  <= d_trap;
                next_pc   <= npc_mux;
                link_addr <= a_seq8;
            end else begin
                taken     <= 1'b0;
                annul     <= 1'b0;
                link_en   <= 1'b0;
                link_rd   <= 1'b0;
                trap_req  <= 1'b0;
            end
        end
    end

    // R1: a valid operation produces a result exactly one cycle later.
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    // R1: idle cycles carry no decision and keep the addresses.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && !taken && !annul && !link_en && !trap_req
                       && $stable(next_pc) && $stable(link_addr)));

    // R7: the delay slot is only cancelled when the branch does not go.
    p_annul_not_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        annul |-> !taken);

    // R12: a trap request never comes with a transfer or a link.
    p_trap_alone_r12: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (!taken && !link_en && !annul));

    // R6: the return address is the instruction address plus eight.
    p_link_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (link_addr == $past(pc) + W'(8)));

    // R9: only the linking register jump writes the destination register.
    p_link_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        link_rd |-> (link_en && taken));
endmodule

// File: tb/sim_bte_top.sv
`timescale 1ns/1ps
// Bench: sweeps every operation code over a grid of operands, immediates
// and addresses, checking each output against an arithmetic model.
module sim_bte_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_code = '0;
    logic [31:0] rs_val = '0, rt_val = '0, pc = '0;
    logic [25:0] offset = '0;
    logic        res_valid, taken, link_en, link_rd, annul, trap_req;
    logic [31:0] next_pc, link_addr;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    bte_top u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .rs_val(rs_val), .rt_val(rt_val), .pc(pc), .offset(offset),
        .res_valid(res_valid), .taken(taken), .next_pc(next_pc),
        .link_addr(link_addr), .link_en(link_en), .link_rd(link_rd),
        .annul(annul), .trap_req(trap_req)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h (op=%0d rs=%h rt=%h pc=%h off=%h)",
                     req, what, act, exp, op_code, rs_val, rt_val, pc, offset);
        end
    endtask

    logic [31:0] last_npc, last_link;

    // Drive one operation and compare against the model one cycle later.
    task automatic run(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] p, input logic [25:0] off);
        logic        e_tk, e_an, e_le, e_lr, e_tr, cnd;
        logic [31:0] e_np, imm32;
        string       rq;
        @(negedge clk);
        op_valid = 1'b1; op_code = op; rs_val = a; rt_val = b; pc = p; offset = off;
        imm32 = {{16{off[15]}}, off[15:0]};
        e_tk = 0; e_an = 0; e_le = 0; e_lr = 0; e_tr = 0; cnd = 0; e_np = p + 32'd4; rq = "";
        if (op < 16) begin
            case (op % 8)
                0: begin cnd = (a == b); rq = "R2"; end
                1: begin cnd = (a != b); rq = "R2"; end
                2: begin cnd = ($signed(a) <= 0); rq = "R3"; end
                3: begin cnd = ($signed(a) > 0); rq = "R3"; end
                4, 6: begin cnd = ($signed(a) < 0); rq = "R4"; end
                default: begin cnd = ($signed(a) >= 0); rq = "R4"; end
            endcase
            e_tk = cnd;
            e_an = (op >= 8) && !cnd;
            e_le = (op % 8 >= 6);
            e_np = cnd ? (p + 32'd4 + (imm32 << 2)) : (p + 32'd8);
        end else if (op < 20) begin
            e_tk = 1;
            e_le = (op == 17) || (op == 19);
            e_lr = (op == 19);
            e_np = (op >= 18) ? a : {p[31:28], off, 2'b00};
            rq = (op >= 18) ? "R9" : "R8";
        end else begin
            logic [31:0] bb;
            bb = (op >= 26) ? imm32 : b;
            rq = (op >= 26) ? "R11" : "R10";
            case ((op >= 26) ? op - 26 : op - 20)
                0: e_tr = (a == bb);
                1: e_tr = (a != bb);
                2: e_tr = ($signed(a) >= $signed(bb));
                3: e_tr = (a >= bb);
                4: e_tr = ($signed(a) < $signed(bb));
                default: e_tr = (a < bb);
            endcase
        end
        @(posedge clk);
        #1;
        chk("R1", "res_valid", {31'b0, res_valid}, 32'd1);
        chk(rq, "taken", {31'b0, taken}, {31'b0, e_tk});
        chk(op >= 20 ? "R12" : (op >= 16 ? rq : "R5"), "next_pc", next_pc, e_np);
        chk("R6", "link_addr", link_addr, p + 32'd8);
        chk(op >= 16 ? rq : "R6", "link_en", {31'b0, link_en}, {31'b0, e_le});
        chk("R9", "link_rd", {31'b0, link_rd}, {31'b0, e_lr});
        chk("R7", "annul", {31'b0, annul}, {31'b0, e_an});
        chk(op >= 20 ? rq : "R12", "trap_req", {31'b0, trap_req}, {31'b0, e_tr});
        last_npc = e_np;
        last_link = p + 32'd8;
    endtask

    // Idle cycle with inputs that would trigger flags if they were not ignored.
    task automatic idle(input logic [4:0] op);
        @(negedge clk);
        op_valid = 1'b0; op_code = op; rs_val = 32'd0; rt_val = 32'd0;
        pc = 32'h1234_5670; offset = 26'h3FF_FFFF;
        @(posedge clk);
        #1;
        chk("R1", "idle res_valid", {31'b0, res_valid}, 32'd0);
        chk("R1", "idle flags", {27'b0, taken, annul, link_en, link_rd, trap_req}, 32'd0);
        chk("R1", "idle next_pc hold", next_pc, last_npc);
        chk("R1", "idle link_addr hold", link_addr, last_link);
    endtask

    logic [31:0] vals [10];
    logic [15:0] imms [6];

    initial begin
        vals = '{32'h0, 32'h1, 32'h2, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h7FFF_FFFF,
                 32'h8000_0000, 32'h8000_0001, 32'h0000_8000, 32'hFFFF_8000};
        imms = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'hFFFE};
        // Reset state (R1).
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "reset flags", {26'b0, res_valid, taken, annul, link_en, link_rd, trap_req}, 32'd0);
        chk("R1", "reset next_pc", next_pc, 32'd0);
        chk("R1", "reset link_addr", link_addr, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int op = 0; op < 32; op++) begin
            for (int ia = 0; ia < 10; ia++) begin
                for (int ib = 0; ib < 10; ib++) begin
                    for (int ii = 0; ii < 6; ii++) begin
                        run(5'(op), vals[ia], vals[ib],
                            32'h9000_0000 + 32'(ia) * 32'h1101_0040 + 32'(ii) * 32'h0000_0104,
                            {10'(ib * 37 + ii), imms[ii]});
                    end
                end
            end
            idle(5'(op));
        end
        // Idle after taken, linking, annulled and trapping results.
        run(5'd17, 32'h0, 32'h0, 32'hC000_0000, 26'h155_5555);
        idle(5'd20);
        run(5'd14, 32'h1, 32'h0, 32'h0000_1000, 26'h0_0010);
        idle(5'd0);
        run(5'd20, 32'h5, 32'h5, 32'h0000_2000, 26'h0);
        idle(5'd19);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule